// File: doc/BRIEF.md
# Trigger Tower Pulse Peak Finder

This block turns the raw digitised pulse of one calorimeter trigger tower into one transverse-energy code per beam crossing. Unsigned 10-bit samples arrive four per crossing. Two of each four samples are kept. They pass through an 8-tap FIR with signed, programmable coefficients. The filtered stream runs at twice the crossing rate and feeds a three-point peak test. The test is evaluated once per crossing, so a slow-rising pulse is credited to the crossing where its filtered shape tops out, not to the crossing where it first rises above a threshold.

At the crossing where the peak test passes, the filtered energy addresses a programmable 2048-entry table, which returns an 8-bit transverse-energy code. At every other crossing the table is addressed with zero. Coefficients and table contents are loaded through an address/data write port. Loads are accepted only while the filter pipeline is held clear by `hold_i`.

Top module: `trig_peak_finder`

## Requirements
- R1: While `rst_ni` is low or `hold_i` is high, `et_vld_o` is low. After `hold_i` is released, the block behaves as if every earlier sample were zero. After `rst_ni`, `et_o` is 0.
- R2: Accepted samples are counted from the release of hold. Within each group of four (index mod 4), the samples at positions 0 and 2 feed the filter as x[2n] and x[2n+1]. The samples at positions 1 and 3 are discarded and have no effect on any output.
- R3: The filtered value is y[m] = sum over j=0..7 of c[j]*x[m-j], where each c[j] is a 6-bit two's-complement coefficient. The result is clamped to the range 0..2047.
- R4: Crossing n is a peak when y[2n] > y[2n-1] and y[2n] >= y[2n+1]. Here y[-1] is 0.
- R5: The energy of a crossing is y[2n] when it is a peak and 0 otherwise. The code output is the table entry at that energy (the bench loads entry 0 with 0).
- R6: Each crossing gives exactly one `et_vld_o` pulse of one cycle. That pulse comes exactly 3 clock cycles after the edge that accepts the crossing's position-2 sample, regardless of idle cycles between samples.
- R7: A write with `cfg_addr_i[11]`=1 loads coefficient `cfg_addr_i[2:0]` from `cfg_data_i[5:0]`. A write with `cfg_addr_i[11]`=0 loads table entry `cfg_addr_i[10:0]` from `cfg_data_i[7:0]`. Writes take effect only while `hold_i` is high and are otherwise ignored.
- R8: `et_o` keeps its value in every cycle in which `et_vld_o` is low.
- R9: A pulse with a flat top that spans several crossings produces exactly one peak.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| hold_i | input | 1 | Holds the pipeline clear and enables configuration writes |
| sample_vld_i | input | 1 | Sample strobe, four per crossing |
| sample_i | input | 10 | Unsigned ADC sample |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 12 | Bit 11 selects coefficient (1) or table (0) |
| cfg_data_i | input | 8 | Write data |
| et_vld_o | output | 1 | One pulse per crossing |
| et_o | output | 8 | Transverse-energy code |

## Verification
The assertions assume that a crossing's position-2 sample is followed by at least three clock cycles without a hold before the next hold begins. They also assume that samples arrive only through `sample_vld_i`. The stimulus meets these assumptions by draining the pipeline for several cycles before every hold. It also changes coefficients and table entries only inside a hold, except for the deliberate out-of-hold writes, which must be ignored. Idle gaps of zero to two cycles are inserted between samples so that the fixed latency is checked against irregular input spacing.

// File: rtl/tpf_pkg.sv
package tpf_pkg;
  localparam int unsigned SAMPLE_W = 10;
  localparam int unsigned COEF_W   = 6;
  localparam int unsigned N_TAPS   = 8;
  localparam int unsigned ENERGY_W = 11;
  localparam int unsigned CODE_W   = 8;
endpackage

// File: rtl/tpf_fir.sv
module tpf_fir #(
  parameter int unsigned XW   = tpf_pkg::SAMPLE_W,
  parameter int unsigned CW   = tpf_pkg::COEF_W,
  parameter int unsigned TAPS = tpf_pkg::N_TAPS,
  parameter int unsigned EW   = tpf_pkg::ENERGY_W,
  localparam int unsigned IW  = $clog2(TAPS),
  localparam int unsigned ACCW = XW + CW + IW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          hold_i,
  input  logic          coef_we_i,
  input  logic [IW-1:0] coef_idx_i,
  input  logic [CW-1:0] coef_i,
  input  logic          x_vld_i,
  input  logic          x_odd_i,
  input  logic [XW-1:0] x_i,
  output logic          y_vld_o,
  output logic          y_odd_o,
  output logic [EW-1:0] y_o
);
  localparam logic signed [ACCW-1:0] EMAX = ACCW'((1 << EW) - 1);

  logic        [XW-1:0]   tap_q  [TAPS];
  logic signed [CW-1:0]   coef_q [TAPS];
  logic signed [ACCW-1:0] prod   [TAPS];
  logic signed [ACCW-1:0] acc;
  logic        [EW-1:0]   y_d;
  logic tap_vld_q, tap_odd_q;

  for (genvar g = 0; g < TAPS; g++) begin : g_mul
    assign prod[g] = ACCW'($signed({1'b0, tap_q[g]})) * ACCW'(coef_q[g]);
  end

  always_comb begin
    acc = '0;
    for (int i = 0; i < TAPS; i++) acc = acc + prod[i];
    if (acc < 0)         y_d = '0;
    else if (acc > EMAX) y_d = '1;
    else                 y_d = acc[EW-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < TAPS; i++) begin
        tap_q[i]  <= '0;
        coef_q[i] <= '0;
      end
      tap_vld_q <= 1'b0;
      tap_odd_q <= 1'b0;
      y_vld_o   <= 1'b0;
      y_odd_o   <= 1'b0;
      y_o       <= '0;
    end else if (hold_i) begin
      for (int i = 0; i < TAPS; i++) tap_q[i] <= '0;
      tap_vld_q <= 1'b0;
      tap_odd_q <= 1'b0;
      y_vld_o   <= 1'b0;
      y_odd_o   <= 1'b0;
      y_o       <= '0;
      if (coef_we_i) coef_q[coef_idx_i] <= coef_i;
    end else begin
      tap_vld_q <= x_vld_i;
      tap_odd_q <= x_odd_i;
      if (x_vld_i) begin
        tap_q[0] <= x_i;
        for (int i = 1; i < TAPS; i++) tap_q[i] <= tap_q[i-1];
      end
      y_vld_o <= tap_vld_q;
      y_odd_o <= tap_odd_q;
      if (tap_vld_q) y_o <= y_d;
    end
  end
endmodule

// File: rtl/tpf_peak.sv
module tpf_peak #(
  parameter int unsigned EW = tpf_pkg::ENERGY_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          hold_i,
  input  logic          y_vld_i,
  input  logic          y_odd_i,
  input  logic [EW-1:0] y_i,
  output logic          e_vld_o,
  output logic [EW-1:0] e_o
);
  logic [EW-1:0] y_old_q, y_mid_q;
  logic          peak_hit;

  // rising into the middle sample, not falling out of it: flat tops give one hit
  assign peak_hit = (y_mid_q > y_old_q) && (y_mid_q >= y_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      y_old_q <= '0;
      y_mid_q <= '0;
      e_vld_o <= 1'b0;
      e_o     <= '0;
    end else if (hold_i) begin
      y_old_q <= '0;
      y_mid_q <= '0;
      e_vld_o <= 1'b0;
      e_o     <= '0;
    end else begin
      e_vld_o <= y_vld_i && y_odd_i;
      if (y_vld_i) begin
        y_old_q <= y_mid_q;
        y_mid_q <= y_i;
        if (y_odd_i) e_o <= peak_hit ? y_mid_q : '0;
      end
    end
  end
endmodule

// File: rtl/tpf_lut.sv
module tpf_lut #(
  parameter int unsigned EW = tpf_pkg::ENERGY_W,
  parameter int unsigned TW = tpf_pkg::CODE_W,
  localparam int unsigned DEPTH = 1 << EW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          hold_i,
  input  logic          we_i,
  input  logic [EW-1:0] waddr_i,
  input  logic [TW-1:0] wdata_i,
  input  logic          e_vld_i,
  input  logic [EW-1:0] e_i,
  output logic          code_vld_o,
  output logic [TW-1:0] code_o
);
  logic [TW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_vld_o <= 1'b0;
      code_o     <= '0;
    end else begin
      code_vld_o <= e_vld_i && !hold_i;
      if (e_vld_i && !hold_i) code_o <= mem_q[e_i];
    end
  end
endmodule

// File: rtl/trig_peak_finder.sv
module trig_peak_finder #(
  parameter int unsigned XW   = tpf_pkg::SAMPLE_W,
  parameter int unsigned CW   = tpf_pkg::COEF_W,
  parameter int unsigned TAPS = tpf_pkg::N_TAPS,
  parameter int unsigned EW   = tpf_pkg::ENERGY_W,
  parameter int unsigned TW   = tpf_pkg::CODE_W,
  localparam int unsigned CAW = EW + 1,
  localparam int unsigned CDW = (TW > CW) ? TW : CW,
  localparam int unsigned IW  = $clog2(TAPS)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           hold_i,
  input  logic           sample_vld_i,
  input  logic [XW-1:0]  sample_i,
  input  logic           cfg_we_i,
  input  logic [CAW-1:0] cfg_addr_i,
  input  logic [CDW-1:0] cfg_data_i,
  output logic           et_vld_o,
  output logic [TW-1:0]  et_o
);
  logic [1:0]    phase_q;
  logic          x_vld, coef_we, lut_we;
  logic          y_vld, y_odd, e_vld;
  logic [EW-1:0] y, e;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           phase_q <= '0;
    else if (hold_i)       phase_q <= '0;
    else if (sample_vld_i) phase_q <= phase_q + 2'd1;
  end

  assign x_vld   = sample_vld_i && !hold_i && !phase_q[0];
  assign coef_we = cfg_we_i && hold_i &&  cfg_addr_i[CAW-1];
  assign lut_we  = cfg_we_i && hold_i && !cfg_addr_i[CAW-1];

  tpf_fir #(.XW(XW), .CW(CW), .TAPS(TAPS), .EW(EW)) u_fir (
    .clk_i, .rst_ni, .hold_i,
    .coef_we_i(coef_we), .coef_idx_i(cfg_addr_i[IW-1:0]), .coef_i(cfg_data_i[CW-1:0]),
    .x_vld_i(x_vld), .x_odd_i(phase_q[1]), .x_i(sample_i),
    .y_vld_o(y_vld), .y_odd_o(y_odd), .y_o(y)
  );

  tpf_peak #(.EW(EW)) u_peak (
    .clk_i, .rst_ni, .hold_i,
    .y_vld_i(y_vld), .y_odd_i(y_odd), .y_i(y),
    .e_vld_o(e_vld), .e_o(e)
  );

  tpf_lut #(.EW(EW), .TW(TW)) u_lut (
    .clk_i, .rst_ni, .hold_i,
    .we_i(lut_we), .waddr_i(cfg_addr_i[EW-1:0]), .wdata_i(cfg_data_i[TW-1:0]),
    .e_vld_i(e_vld), .e_i(e),
    .code_vld_o(et_vld_o), .code_o(et_o)
  );
endmodule

// File: rtl/tpf_checker.sv
module tpf_checker #(
  parameter int unsigned TW = tpf_pkg::CODE_W
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          hold_i,
  input logic          sample_vld_i,
  input logic          et_vld_o,
  input logic [TW-1:0] et_o
);
  p_hold_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> !et_vld_o);

  p_single_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    et_vld_o |=> !et_vld_o);

  p_latency_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    et_vld_o |-> $past(sample_vld_i && !hold_i, 4));

  p_code_stable_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !et_vld_o |-> $stable(et_o));
endmodule

bind trig_peak_finder tpf_checker #(.TW(TW)) u_tpf_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .hold_i(hold_i),
  .sample_vld_i(sample_vld_i), .et_vld_o(et_vld_o), .et_o(et_o)
);

// File: tb/trig_peak_finder_bench.sv
module trig_peak_finder_bench;
  logic        clk = 1'b0;
  logic        rst_n, hold, svld, cfg_we, et_vld;
  logic [9:0]  sample;
  logic [11:0] cfg_addr;
  logic [7:0]  cfg_data, et;

  always #4 clk = ~clk;

  trig_peak_finder u_trig_peak_finder (
    .clk_i(clk), .rst_ni(rst_n), .hold_i(hold),
    .sample_vld_i(svld), .sample_i(sample),
    .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_data_i(cfg_data),
    .et_vld_o(et_vld), .et_o(et)
  );

  typedef struct { int code; int due; } exp_t;
  exp_t q[$];
  exp_t item;

  int cyc = 0, checks = 0, fails = 0, nz = 0, last_code = 0;
  int coef_m[8], lut_m[2048], xh[8];
  int k = 0, y_even = 0, y_prev_odd = 0;
  int unsigned lfsr = 32'h1234_5678;
  string cur_req = "R5";
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d cyc=%0d", req, act, expv, cyc);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (et_vld) begin
        if (q.size() == 0) chk(0, "R6", int'(et), -1);
        else begin
          item = q.pop_front();
          chk(int'(et) == item.code, cur_req, int'(et), item.code);
          chk(cyc == item.due, "R6", cyc, item.due);
        end
        if (et != 0) nz++;
        last_code = int'(et);
      end else if (int'(et) != last_code) chk(0, "R8", int'(et), last_code);
    end
  end

  function automatic int fir_y();
    int acc = 0;
    for (int j = 0; j < 8; j++) acc += coef_m[j] * xh[j];
    if (acc < 0) return 0;
    if (acc > 2047) return 2047;
    return acc;
  endfunction

  task automatic model_clear();
    k = 0; y_even = 0; y_prev_odd = 0;
    for (int j = 0; j < 8; j++) xh[j] = 0;
  endtask

  task automatic cfg_write(int addr, int data);
    cfg_we = 1; cfg_addr = 12'(addr); cfg_data = 8'(data);
    if (hold) begin  // R7: only applied under hold
      if (addr >= 2048) coef_m[addr & 7] = ((data & 63) >= 32) ? (data & 63) - 64 : (data & 63);
      else lut_m[addr] = data & 255;
    end
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic send(int v, int gap);
    int ph, y, e;
    svld = 1; sample = 10'(v);
    ph = k % 4;
    if (ph % 2 == 0) begin
      for (int j = 7; j > 0; j--) xh[j] = xh[j-1];
      xh[0] = v;
      y = fir_y();
      if (ph == 0) y_even = y;
      else begin
        e = (y_even > y_prev_odd && y_even >= y) ? y_even : 0;
        q.push_back('{code: lut_m[e], due: cyc + 4});
        y_prev_odd = y;
      end
    end
    k++;
    @(negedge clk);
    svld = 0;
    repeat (gap) @(negedge clk);
  endtask

  // R2: positions 1 and 3 carry junk that must not matter
  task automatic xing(int a, int b, int gap);
    send(a, gap); send(1000 - a / 2, gap); send(b, gap); send(977, gap);
  endtask

  task automatic enter_hold();
    repeat (8) @(negedge clk);
    hold = 1; @(negedge clk);
    model_clear();
  endtask

  task automatic leave_hold();
    hold = 0; @(negedge clk);
  endtask

  task automatic load_coefs(input int c[8]);
    for (int j = 0; j < 8; j++) cfg_write(2048 + j, c[j] & 63);
  endtask

  initial begin
    rst_n = 0; hold = 1; svld = 0; sample = '0; cfg_we = 0; cfg_addr = '0; cfg_data = '0;
    model_clear();
    repeat (3) @(negedge clk);
    chk(et_vld == 0, "R1", int'(et_vld), 0);
    chk(et == 0, "R1", int'(et), 0);
    rst_n = 1;
    @(negedge clk);
    for (int a = 0; a < 2048; a++)
      cfg_write(a, (a == 0) ? 0 : (a == 2047) ? 171 : ((a * 37 + 11) % 255) + 1);
    load_coefs('{1, 0, 0, 0, 0, 0, 0, 0});
    repeat (2) @(negedge clk);
    chk(et_vld == 0, "R1", int'(et_vld), 0);
    leave_hold();

    // R9, R4: flat top over three crossings gives one peak
    cur_req = "R9"; nz = 0;
    xing(0, 0, 0); xing(0, 0, 1);
    xing(50, 50, 0); xing(50, 50, 0); xing(50, 50, 2);
    xing(0, 0, 0); xing(0, 0, 0);
    repeat (8) @(negedge clk);
    chk(nz == 1, "R9", nz, 1);

    // R4, R5: rise on the odd slot is not a peak; then a clean even-slot peak
    cur_req = "R4";
    xing(0, 80, 0); xing(20, 0, 1); xing(0, 0, 0);
    xing(10, 30, 0); xing(60, 40, 0); xing(5, 0, 0);

    // R7: writes outside hold are ignored
    cur_req = "R7";
    cfg_write(2048, 31);
    cfg_write(5, 238);
    xing(0, 0, 0); xing(5, 0, 0); xing(0, 0, 0);

    // R3: clamp at the top of the range
    enter_hold();
    load_coefs('{2, 4, 6, 8, 8, 6, 4, 2});
    leave_hold();
    cur_req = "R3";
    xing(0, 0, 0); xing(1023, 1023, 1); xing(1023, 0, 0); xing(0, 0, 0);
    xing(3, 7, 0); xing(12, 4, 0); xing(0, 0, 0); xing(0, 0, 0);

    // R3, R1: signed coefficients incl. -32 and 31, clamp at 0, history cleared by hold
    enter_hold();
    load_coefs('{-32, 5, 12, 20, 14, 6, -2, 31});
    leave_hold();
    cur_req = "R3";
    for (int n = 0; n < 150; n++) begin
      int a, b, g;
      lfsr = lfsr * 1103515245 + 12345; a = int'((lfsr >> 8) % 1024);
      lfsr = lfsr * 1103515245 + 12345; b = int'((lfsr >> 8) % 1024);
      lfsr = lfsr * 1103515245 + 12345; g = int'((lfsr >> 8) % 3);
      if (n % 5 == 0) a = 0;
      xing(a / ((n % 4) + 1), b / ((n % 3) + 1), g);
    end

    // R6: queue fully drained
    repeat (10) @(negedge clk);
    chk(q.size() == 0, "R6", q.size(), 0);

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      chk(0, "watchdog", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule